// File: doc/BRIEF.md
# Power Management Timer with Half-Period Status

The block is a free-running up-counter, 24 bits wide by default, that advances by one on each clock cycle in which a fixed-rate tick strobe is high. The strobe stands in for the slow timebase of roughly 3.58 MHz that such a timer runs from. Counting is gated by a run bit. When the run bit is clear the counter keeps its value. Software cannot load or reset the count. It only has to run from power-up.

Each change of the counter's top bit sets a sticky status flag. A change from 0 to 1 sets it, and so does a change from 1 to 0, which happens on the wrap from all ones to zero. The flag therefore sets every half period of the counter. While the flag and an interrupt enable bit are both 1, the block asserts a request to the system-control interrupt logic.

Software reads the count as three bytes through a small byte-wide register port. Reading the low byte captures the upper bytes, so the three reads return one consistent value.

The status flag is held by a two-state machine. `ST_IDLE` means the flag is clear. `ST_PEND` means the flag is set. The machine moves from ST_IDLE to ST_PEND on a top-bit flip. It moves from ST_PEND to ST_IDLE on a write-1 clear, but only when no flip happens in the same cycle. In every other case it stays in its current state.

Top module: `pm_timer`

## Requirements
- R1: After reset the count is 0, the status flag is 0, the interrupt enable is 0 and the run bit is 1. The control register at address 4 then reads 8'h02.
- R2: In each cycle where tick is 1 and the run bit is 1, the count rises by exactly one. In a cycle where tick is 0, the count does not change.
- R3: While the run bit is 0, tick strobes are ignored and the count holds its value.
- R4: The status flag (address 3, bit 0) sets on the clock edge where the counter's top bit (bit 23 at the default width) goes from 0 to 1.
- R5: The count wraps from all ones to zero. That wrap is a 1-to-0 change of the top bit, and it also sets the status flag.
- R6: Writing a 1 to address 3 bit 0 clears the status flag. Writing a 0 there leaves it unchanged. If a top-bit flip happens in the same cycle as the clear, the flag stays set.
- R7: sci_req is 1 exactly when the status flag is 1 and the interrupt enable is 1.
- R8: Address 0 reads the live low byte of the count. Reading address 0 captures the upper bytes. Addresses 1 and 2 return count bits 15:8 and 23:16 as they were at the last read of address 0.
- R9: Address 4 is the control register: bit 0 is the interrupt enable and bit 1 is the run bit. Writes to the count bytes at addresses 0 to 2 are ignored.
- R10: Addresses 5, 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Fixed-rate count strobe, one cycle per count |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 0 captures the upper bytes |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| sci_req | output | 1 | Interrupt request to the system-control interrupt logic |

## Verification
The counting path is driven by several tick patterns: bursts of ticks, idle gaps, ticks while the run bit is off, and long continuous runs. Together these separate a counter that steps on every tick from one that is stuck, free-running or ignores the run gate. The status flag is driven to the rising edge of the top bit and to the wrap edge, which catches a design that flags only one direction of change. The flag is also hit by a clear in the very cycle of a flip, which separates set-wins priority from clear-wins priority. A second instance with a 16-bit counter reaches these edges within a short run. The byte reads are taken after the count has moved past the captured value, so a live read of the upper bytes differs from a captured one.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
    localparam int ADDR_W      = 3;
    localparam int DATA_W      = 8;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;
    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_ON_BIT = 1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } pmt_stat_e;
endpackage

// File: rtl/pmt_counter.sv
module pmt_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             on_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flip_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             adv;

    assign adv = tick_i && on_i;
    // The top bit changes exactly when all lower bits are ones and the counter advances.
    assign flip_o = adv && (&cnt_q[CNT_W-2:0]);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> cnt_q == $past(cnt_q) + 1'b1);
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q));
    a_r3_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !on_i |=> $stable(cnt_q));
    a_r4_flip_moves_top: assert property (@(posedge clk) disable iff (!rst_n)
        flip_o |=> cnt_q[CNT_W-1] != $past(cnt_q[CNT_W-1]));
endmodule

// File: rtl/pmt_status.sv
module pmt_status
    import pmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flip_i,
    input  logic clr_i,
    output logic stat_o
);
    pmt_stat_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (flip_i) st_d = ST_PEND;
            ST_PEND: if (clr_i && !flip_i) st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        stat_o = (st_q == ST_PEND);
    end

    a_r4_flip_sets: assert property (@(posedge clk) disable iff (!rst_n)
        flip_i |=> stat_o);
    a_r6_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !flip_i |=> !stat_o);
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o && !clr_i |=> stat_o);
endmodule

// File: rtl/pmt_regs.sv
module pmt_regs
    import pmt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              stat_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              clr_o,
    output logic              en_o,
    output logic              on_o
);
    localparam int NBYTES = CNT_W / DATA_W;
    localparam int SNAP_W = CNT_W - DATA_W;

    logic [SNAP_W-1:0] snap_q;
    logic              en_q;
    logic              on_q;
    logic [DATA_W-1:0] byte_w [NBYTES];
    logic              unused_wdata;

    assign unused_wdata = ^wdata_i[DATA_W-1:2];

    assign byte_w[0] = cnt_i[DATA_W-1:0];
    generate
        for (genvar g = 1; g < NBYTES; g++) begin : g_byte
            assign byte_w[g] = snap_q[DATA_W*g-1 -: DATA_W];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (rd_i && addr_i == '0) begin
            snap_q <= cnt_i[CNT_W-1:DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            on_q <= 1'b1;
        end else if (wr_i && addr_i == A_CTRL) begin
            en_q <= wdata_i[CTRL_EN_BIT];
            on_q <= wdata_i[CTRL_ON_BIT];
        end
    end

    assign clr_o = wr_i && (addr_i == A_STAT) && wdata_i[0];
    assign en_o  = en_q;
    assign on_o  = on_q;

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NBYTES; k++) begin
            if (addr_i == ADDR_W'(k)) rdata_o = byte_w[k];
        end
        if (addr_i == A_STAT) rdata_o = {{(DATA_W-1){1'b0}}, stat_i};
        if (addr_i == A_CTRL) rdata_o = {{(DATA_W-2){1'b0}}, on_q, en_q};
    end

    a_r8_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i && addr_i == '0 |=> snap_q == $past(cnt_i[CNT_W-1:DATA_W]));
    a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == A_CTRL) |=> $stable({en_q, on_q}));
endmodule

// File: rtl/pm_timer.sv
module pm_timer
    import pmt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sci_req
);
    logic [CNT_W-1:0] cnt;
    logic             flip;
    logic             clr;
    logic             stat;
    logic             en;
    logic             on;

    pmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .on_i   (on),
        .cnt_o  (cnt),
        .flip_o (flip)
    );

    pmt_status u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .flip_i (flip),
        .clr_i  (clr),
        .stat_o (stat)
    );

    pmt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .rd_i    (reg_rd),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .cnt_i   (cnt),
        .stat_i  (stat),
        .rdata_o (reg_rdata),
        .clr_o   (clr),
        .en_o    (en),
        .on_o    (on)
    );

    assign sci_req = stat && en;

    a_r7_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        sci_req |-> u_regs.en_o);
endmodule

// File: tb/pm_timer_tb.sv
module pm_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] rd_a, rd_b;
    logic       sci_a, sci_b;

    int  vectors = 0;
    int  fails = 0;
    int  cycles = 0;
    bit  armed = 1'b0;
    bit  done = 1'b0;

    longint m_cnt [2] = '{0, 0};
    longint m_snap[2] = '{0, 0};
    bit     m_stat[2] = '{0, 0};
    bit     m_en  [2] = '{0, 0};
    bit     m_on  [2] = '{1, 1};
    longint t_top, t_mask, t_nxt;
    bit     t_adv, t_flip;

    always #5 clk = ~clk;

    pm_timer #(.CNT_W(24)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_a), .sci_req(sci_a));

    pm_timer #(.CNT_W(16)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_b), .sci_req(sci_b));

    function automatic int wid(int i);
        return (i == 0) ? 24 : 16;
    endfunction

    // Behavioural reference model, one entry per instance.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] <= 0; m_snap[i] <= 0; m_stat[i] <= 0; m_en[i] <= 0; m_on[i] <= 1;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                t_top  = longint'(1) << (wid(i) - 1);
                t_mask = (longint'(1) << wid(i)) - 1;
                t_adv  = tick && m_on[i];
                t_nxt  = t_adv ? ((m_cnt[i] + 1) & t_mask) : m_cnt[i];
                t_flip = ((t_nxt & t_top) != (m_cnt[i] & t_top));
                if (t_flip) m_stat[i] <= 1'b1;
                else if (reg_wr && reg_addr == 3'd3 && reg_wdata[0]) m_stat[i] <= 1'b0;
                if (reg_wr && reg_addr == 3'd4) begin
                    m_en[i] <= reg_wdata[0];
                    m_on[i] <= reg_wdata[1];
                end
                if (reg_rd && reg_addr == 3'd0) m_snap[i] <= m_cnt[i] >> 8;
                m_cnt[i] <= t_nxt;
            end
        end
    end

    function automatic logic [7:0] exp_rd(int i, logic [2:0] a);
        case (a)
            3'd0: return 8'(m_cnt[i] & 255);
            3'd1: return 8'(m_snap[i] & 255);
            3'd2: return (i == 0) ? 8'((m_snap[i] >> 8) & 255) : 8'd0;
            3'd3: return {7'd0, m_stat[i]};
            3'd4: return {6'd0, m_on[i], m_en[i]};
            default: return 8'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] a);
        case (a)
            3'd0, 3'd1, 3'd2: return "R8";
            3'd3: return "R6";
            3'd4: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (armed && !done) begin
            chk(tag_of(reg_addr), 32'(rd_a), 32'(exp_rd(0, reg_addr)));
            chk(tag_of(reg_addr), 32'(rd_b), 32'(exp_rd(1, reg_addr)));
            chk("R7", 32'(sci_a), 32'(m_stat[0] && m_en[0]));
            chk("R7", 32'(sci_b), 32'(m_stat[1] && m_en[1]));
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 190000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<190000 cycles", cycles);
            finish_run();
        end
    end

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 8'd0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] va, output logic [7:0] vb);
        @(posedge clk); #1;
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        va = rd_a; vb = rd_b;
        @(posedge clk); #1;
        reg_rd = 1'b0; reg_addr = 3'd0;
    endtask

    task automatic ticks(int n);
        @(posedge clk); #1;
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic run_to(longint target);
        @(posedge clk); #1;
        tick = 1'b1;
        while (m_cnt[1] != target) begin
            @(posedge clk); #1;
        end
        tick = 1'b0;
    endtask

    initial begin
        logic [7:0] va, vb;
        #2 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        armed = 1'b1;

        // R1: reset values
        rd(3'd4, va, vb); chk("R1", 32'(va), 32'h02); chk("R1", 32'(vb), 32'h02);
        rd(3'd3, va, vb); chk("R1", 32'(va), 32'h00);
        rd(3'd0, va, vb); chk("R1", 32'(va), 32'h00);

        // R2: five ticks give five counts, idle cycles change nothing
        ticks(5);
        rd(3'd0, va, vb); chk("R2", 32'(va), 32'd5); chk("R2", 32'(vb), 32'd5);
        repeat (4) @(posedge clk);
        rd(3'd0, va, vb); chk("R2", 32'(va), 32'd5);

        // R3: run bit off, ticks ignored
        wr(3'd4, 8'h00);
        ticks(10);
        rd(3'd0, va, vb); chk("R3", 32'(va), 32'd5); chk("R3", 32'(vb), 32'd5);
        rd(3'd4, va, vb); chk("R9", 32'(va), 32'h00);
        wr(3'd4, 8'h02);

        // R9: count bytes are read-only
        wr(3'd0, 8'hAA); wr(3'd1, 8'h55);
        rd(3'd0, va, vb); chk("R9", 32'(va), 32'd5);

        // R10: unused addresses
        rd(3'd7, va, vb); chk("R10", 32'(va), 32'h00);
        rd(3'd5, va, vb); chk("R10", 32'(vb), 32'h00);

        // R4 and R7: enable interrupt, drive the small counter over its top-bit rise
        wr(3'd4, 8'h03);
        run_to(32767);
        rd(3'd3, va, vb); chk("R4", 32'(vb), 32'd0);
        ticks(1);
        rd(3'd3, va, vb); chk("R4", 32'(vb), 32'd1); chk("R4", 32'(va), 32'd0);
        @(negedge clk); chk("R7", 32'(sci_b), 32'd1); chk("R7", 32'(sci_a), 32'd0);

        // R8: capture at 0x008000, then move on and read the captured bytes
        rd(3'd0, va, vb); chk("R8", 32'(va), 32'h00);
        ticks(300);
        rd(3'd1, va, vb); chk("R8", 32'(va), 32'h80); chk("R8", 32'(vb), 32'h80);
        rd(3'd2, va, vb); chk("R8", 32'(va), 32'h00);

        // R6: write 0 keeps the flag, write 1 clears it
        wr(3'd3, 8'h00);
        rd(3'd3, va, vb); chk("R6", 32'(vb), 32'd1);
        wr(3'd3, 8'h01);
        rd(3'd3, va, vb); chk("R6", 32'(vb), 32'd0);
        @(negedge clk); chk("R7", 32'(sci_b), 32'd0);

        // R5: wrap of the small counter sets the flag
        run_to(65535);
        ticks(1);
        rd(3'd3, va, vb); chk("R5", 32'(vb), 32'd1);
        rd(3'd0, va, vb); chk("R5", 32'(vb), 32'h00); chk("R2", 32'(va), 32'h00);
        rd(3'd2, va, vb); chk("R8", 32'(va), 32'h01);

        // R7: enable off masks the request while the flag stays set
        wr(3'd4, 8'h02);
        rd(3'd3, va, vb); chk("R7", 32'(vb), 32'd1);
        @(negedge clk); chk("R7", 32'(sci_b), 32'd0);

        // R6: clear in the same cycle as a flip loses to the flip
        wr(3'd3, 8'h01);
        run_to(32767);
        @(posedge clk); #1;
        tick = 1'b1; reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h01;
        @(posedge clk); #1;
        tick = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 8'h00;
        rd(3'd3, va, vb); chk("R6", 32'(vb), 32'd1); chk("R6", 32'(va), 32'd0);

        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule